// File: doc/BRIEF.md
# Wrapping Hardware Stack with Interrupt Context Saver

This block keeps the call and interrupt stack of a small 8-bit processor. Its stack pointer is 16 bits wide. Only the low six bits can change, so the pointer always stays inside the 64-byte window from 00C0h to 00FFh. When the pointer moves past either end of that window it wraps to the other end and gives no warning. The processor gives the block single-cycle command pulses: push or pop one byte, call or return (two bytes of program counter), interrupt entry or interrupt return (five bytes of context), and a stack-pointer reset. The block then runs the matching frame on a byte-wide synchronous RAM port, one access per clock.

The block also holds the interrupt mask bit of the condition code byte. Interrupt entry sets the mask. Interrupt return loads the mask from the saved condition code. An interrupt request that arrives while the mask is set stays latched. It is offered to the processor as a grant once the mask is clear and the block is idle. The pointer always addresses the next free byte. A write uses the current location and then moves the pointer down. A read moves the pointer up first and then reads.

Top module: `stk_ctx_unit`

## Requirements
- R1: After reset, sp is 00FFh, busy, imask and irq_grant are 0, and neither ram_we nor ram_re is asserted.
- R2: A push writes push_data at the address in sp, and sp then drops by one. A pop first raises sp by one and reads that address. pop_valid then pulses with pop_data in the first idle cycle after the frame.
- R3: sp[15:6] is always 0000000011b. A decrement from 00C0h gives 00FFh, an increment from 00FFh gives 00C0h, and no output signals either wrap.
- R4: A call writes pc_in[7:0] at sp and pc_in[15:8] at sp-1, and sp drops by two. A return reads the high byte first and then the low byte, and shows the restored value on pc_out while ret_valid pulses. sp rises by two.
- R5: Interrupt entry writes five bytes at falling addresses starting at sp, in this order: PC low, PC high, x_in, a_in, then cc_in with bit 3 replaced by the mask value held before entry. sp drops by five.
- R6: imask reads 1 in the cycle after the block accepts interrupt entry.
- R7: Interrupt return reads the condition code, A, X, PC high and PC low, in that order, from rising addresses. It shows them on cc_out, a_out, x_out and pc_out while iret_valid pulses, and from the next cycle imask equals cc_out bit 3.
- R8: Each clock makes at most one RAM access. After acceptance, busy stays high for 1, 2, 2, 3, 5 and 6 cycles for push, pop, call, return, interrupt entry and interrupt return. Commands that arrive while busy is high are ignored.
- R9: A stack-pointer reset command sets sp to 00FFh in the next cycle, with no RAM access and no busy cycle.
- R10: An irq_req pulse sets a pending flag, and interrupt entry clears it. A request in the same cycle as entry acceptance stays pending. irq_grant equals pending AND NOT imask AND NOT busy.
- R11: When several commands arrive in one idle cycle, only one is taken. The order, highest first, is stack-pointer reset, interrupt entry, interrupt return, call, return, push, pop.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cmd_push | input | 1 | Push one byte |
| cmd_pop | input | 1 | Pop one byte |
| cmd_call | input | 1 | Save program counter for a subroutine call |
| cmd_ret | input | 1 | Restore program counter on subroutine return |
| cmd_int | input | 1 | Interrupt entry, save five-byte context |
| cmd_iret | input | 1 | Interrupt return, restore five-byte context |
| cmd_sp_rst | input | 1 | Reload stack pointer to the top of the window |
| push_data | input | 8 | Byte for a push |
| pc_in | input | 16 | Program counter to save |
| a_in | input | 8 | Accumulator to save |
| x_in | input | 8 | X index to save |
| cc_in | input | 8 | Condition code to save (mask bit supplied internally) |
| irq_req | input | 1 | Interrupt request pulse |
| ram_rdata | input | 8 | Read data, valid the cycle after ram_re |
| ram_addr | output | 16 | RAM address |
| ram_we | output | 1 | RAM write strobe |
| ram_re | output | 1 | RAM read strobe |
| ram_wdata | output | 8 | RAM write data |
| busy | output | 1 | A multi-cycle frame is in progress |
| sp | output | 16 | Current stack pointer |
| pop_data | output | 8 | Popped byte |
| pop_valid | output | 1 | pop_data valid pulse |
| pc_out | output | 16 | Restored program counter |
| ret_valid | output | 1 | Subroutine return complete pulse |
| a_out | output | 8 | Restored accumulator |
| x_out | output | 8 | Restored X index |
| cc_out | output | 8 | Restored condition code |
| iret_valid | output | 1 | Interrupt return complete pulse |
| imask | output | 1 | Interrupt mask bit |
| irq_grant | output | 1 | Pending interrupt may be taken |

## Verification
A new interrupt request can arrive in the same clock in which the block accepts interrupt entry. The entry clears the pending flag while the request sets it. The bench provokes this by pulsing irq_req together with cmd_int, both directed and at random. It judges the result at the ports: irq_grant stays low while the mask is set and rises after the interrupt return that clears the mask. The bench also raises several commands together in one idle cycle and checks that only the higher-priority one shows up in sp and in the RAM contents.

// File: rtl/stk_pkg.sv
package stk_pkg;

  typedef enum logic [2:0] {
    K_NONE,
    K_PUSH,
    K_POP,
    K_CALL,
    K_RET,
    K_INT,
    K_IRET
  } op_kind_t;

  typedef enum logic [1:0] {
    S_IDLE,
    S_WR,
    S_RD,
    S_DRAIN
  } seq_st_t;

  localparam int FRAME_MAX = 5;

  function automatic logic [2:0] frame_len(op_kind_t k);
    case (k)
      K_CALL, K_RET: frame_len = 3'd2;
      K_INT, K_IRET: frame_len = 3'd5;
      default:       frame_len = 3'd1;
    endcase
  endfunction

  function automatic logic is_write(op_kind_t k);
    is_write = (k == K_PUSH) || (k == K_CALL) || (k == K_INT);
  endfunction

endpackage

// File: rtl/stk_sp.sv
module stk_sp #(
  parameter int PTR_W = 6
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             load_top,
  input  logic             dec,
  input  logic             inc,
  output logic [PTR_W-1:0] ptr
);

  logic [PTR_W-1:0] ptr_n;

  always_comb begin
    ptr_n = ptr;
    if (load_top)  ptr_n = '1;
    else if (dec)  ptr_n = ptr - 1'b1;
    else if (inc)  ptr_n = ptr + 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) ptr <= '1;
    else        ptr <= ptr_n;
  end

  AST_TOP_LOAD: assert property (@(posedge clk) disable iff (!rst_n)
    load_top |=> (&ptr)); // R9

endmodule

// File: rtl/stk_imask.sv
module stk_imask (
  input  logic clk,
  input  logic rst_n,
  input  logic int_acc,
  input  logic iret_done,
  input  logic restored_i,
  input  logic irq_req,
  input  logic busy,
  output logic imask,
  output logic irq_grant
);

  logic imask_n;
  logic pend_q, pend_n;

  always_comb begin
    imask_n = imask;
    if (int_acc)        imask_n = 1'b1;
    else if (iret_done) imask_n = restored_i;
    pend_n = irq_req | (pend_q & ~int_acc);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      imask  <= 1'b0;
      pend_q <= 1'b0;
    end else begin
      imask  <= imask_n;
      pend_q <= pend_n;
    end
  end

  assign irq_grant = pend_q & ~imask & ~busy;

  AST_INT_SETS_I: assert property (@(posedge clk) disable iff (!rst_n)
    int_acc |=> imask); // R6
  AST_IRET_LOADS_I: assert property (@(posedge clk) disable iff (!rst_n)
    (iret_done && !int_acc) |=> (imask == $past(restored_i))); // R7
  AST_PEND_KEPT: assert property (@(posedge clk) disable iff (!rst_n)
    (pend_q && !int_acc) |=> pend_q); // R10

endmodule

// File: rtl/stk_seq.sv
module stk_seq
  import stk_pkg::*;
#(
  parameter int          PTR_W = 6,
  parameter logic [15:0] BASE  = 16'h00C0,
  parameter int          IBIT  = 3
) (
  input  logic                   clk,
  input  logic                   rst_n,
  input  logic                   cmd_push,
  input  logic                   cmd_pop,
  input  logic                   cmd_call,
  input  logic                   cmd_ret,
  input  logic                   cmd_int,
  input  logic                   cmd_iret,
  input  logic                   cmd_sp_rst,
  input  logic [7:0]             push_data,
  input  logic [15:0]            pc_in,
  input  logic [7:0]             a_in,
  input  logic [7:0]             x_in,
  input  logic [7:0]             cc_in,
  input  logic                   imask,
  input  logic [PTR_W-1:0]       ptr,
  input  logic [7:0]             ram_rdata,
  output logic                   sp_load,
  output logic                   sp_dec,
  output logic                   sp_inc,
  output logic [15:0]            ram_addr,
  output logic                   ram_we,
  output logic                   ram_re,
  output logic [7:0]             ram_wdata,
  output logic                   busy,
  output logic                   int_acc,
  output op_kind_t               done_kind,
  output logic [8*FRAME_MAX-1:0] frame_flat
);

  localparam int HI_W = 16 - PTR_W;
  localparam logic [HI_W-1:0] BASE_HI = BASE[15:PTR_W];

  seq_st_t    st_q, st_n;
  op_kind_t   kind_q, kind_n, acc_kind, done_q, done_n;
  logic [2:0] idx_q, idx_n, last_q, last_n, slot_q, slot_n;
  logic       cap_q, cap_n;
  logic       acc_rst;
  logic [7:0] cc_frame;
  logic [7:0] fr_q [FRAME_MAX];
  logic [7:0] fr_n [FRAME_MAX];
  logic [PTR_W-1:0] ptr_up;

  assign ptr_up = ptr + 1'b1;

  // command acceptance with fixed priority, only when idle
  always_comb begin
    acc_rst  = 1'b0;
    acc_kind = K_NONE;
    if (st_q == S_IDLE) begin
      if      (cmd_sp_rst) acc_rst  = 1'b1;
      else if (cmd_int)    acc_kind = K_INT;
      else if (cmd_iret)   acc_kind = K_IRET;
      else if (cmd_call)   acc_kind = K_CALL;
      else if (cmd_ret)    acc_kind = K_RET;
      else if (cmd_push)   acc_kind = K_PUSH;
      else if (cmd_pop)    acc_kind = K_POP;
    end
  end

  always_comb begin
    cc_frame       = cc_in;
    cc_frame[IBIT] = imask;
  end

  always_comb begin
    st_n      = st_q;
    kind_n    = kind_q;
    idx_n     = idx_q;
    last_n    = last_q;
    slot_n    = slot_q;
    cap_n     = 1'b0;
    done_n    = K_NONE;
    sp_load   = 1'b0;
    sp_dec    = 1'b0;
    sp_inc    = 1'b0;
    ram_we    = 1'b0;
    ram_re    = 1'b0;
    ram_addr  = {BASE_HI, ptr};
    ram_wdata = 8'h00;
    for (int i = 0; i < FRAME_MAX; i++) fr_n[i] = fr_q[i];
    if (cap_q) fr_n[slot_q] = ram_rdata;

    case (st_q)
      S_IDLE: begin
        if (acc_rst) begin
          sp_load = 1'b1;
        end else if (acc_kind != K_NONE) begin
          kind_n = acc_kind;
          idx_n  = 3'd0;
          last_n = frame_len(acc_kind) - 3'd1;
          if (is_write(acc_kind)) begin
            st_n    = S_WR;
            fr_n[0] = (acc_kind == K_PUSH) ? push_data : pc_in[7:0];
            fr_n[1] = pc_in[15:8];
            fr_n[2] = x_in;
            fr_n[3] = a_in;
            fr_n[4] = cc_frame;
          end else begin
            st_n = S_RD;
          end
        end
      end
      S_WR: begin
        ram_we    = 1'b1;
        ram_wdata = fr_q[idx_q];
        sp_dec    = 1'b1;
        if (idx_q == last_q) st_n  = S_IDLE;
        else                 idx_n = idx_q + 3'd1;
      end
      S_RD: begin
        ram_re   = 1'b1;
        ram_addr = {BASE_HI, ptr_up};
        sp_inc   = 1'b1;
        cap_n    = 1'b1;
        slot_n   = last_q - idx_q;
        if (idx_q == last_q) st_n  = S_DRAIN;
        else                 idx_n = idx_q + 3'd1;
      end
      S_DRAIN: begin
        st_n   = S_IDLE;
        done_n = kind_q;
      end
      default: st_n = S_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st_q   <= S_IDLE;
      kind_q <= K_NONE;
      done_q <= K_NONE;
      idx_q  <= 3'd0;
      last_q <= 3'd0;
      slot_q <= 3'd0;
      cap_q  <= 1'b0;
      for (int i = 0; i < FRAME_MAX; i++) fr_q[i] <= 8'h00;
    end else begin
      st_q   <= st_n;
      kind_q <= kind_n;
      done_q <= done_n;
      idx_q  <= idx_n;
      last_q <= last_n;
      slot_q <= slot_n;
      cap_q  <= cap_n;
      for (int i = 0; i < FRAME_MAX; i++) fr_q[i] <= fr_n[i];
    end
  end

  generate
    for (genvar g = 0; g < FRAME_MAX; g++) begin : g_flat
      assign frame_flat[8*g +: 8] = fr_q[g];
    end
  endgenerate

  assign busy      = (st_q != S_IDLE);
  assign int_acc   = (acc_kind == K_INT);
  assign done_kind = done_q;

  AST_ACCEPT_STARTS: assert property (@(posedge clk) disable iff (!rst_n)
    (acc_kind != K_NONE) |=> busy); // R8
  AST_DRAIN_AFTER_READ: assert property (@(posedge clk) disable iff (!rst_n)
    (st_q == S_DRAIN) |-> $past(ram_re)); // R8

endmodule

// File: rtl/stk_ctx_unit.sv
module stk_ctx_unit
  import stk_pkg::*;
#(
  parameter int          PTR_W = 6,
  parameter logic [15:0] BASE  = 16'h00C0,
  parameter int          IBIT  = 3
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        cmd_push,
  input  logic        cmd_pop,
  input  logic        cmd_call,
  input  logic        cmd_ret,
  input  logic        cmd_int,
  input  logic        cmd_iret,
  input  logic        cmd_sp_rst,
  input  logic [7:0]  push_data,
  input  logic [15:0] pc_in,
  input  logic [7:0]  a_in,
  input  logic [7:0]  x_in,
  input  logic [7:0]  cc_in,
  input  logic        irq_req,
  input  logic [7:0]  ram_rdata,
  output logic [15:0] ram_addr,
  output logic        ram_we,
  output logic        ram_re,
  output logic [7:0]  ram_wdata,
  output logic        busy,
  output logic [15:0] sp,
  output logic [7:0]  pop_data,
  output logic        pop_valid,
  output logic [15:0] pc_out,
  output logic        ret_valid,
  output logic [7:0]  a_out,
  output logic [7:0]  x_out,
  output logic [7:0]  cc_out,
  output logic        iret_valid,
  output logic        imask,
  output logic        irq_grant
);

  localparam int HI_W = 16 - PTR_W;
  localparam logic [HI_W-1:0] BASE_HI = BASE[15:PTR_W];

  logic                   rs_q1, rs_q2, rst_core_n;
  logic                   sp_load, sp_dec, sp_inc, int_acc;
  logic [PTR_W-1:0]       ptr;
  op_kind_t               done_kind;
  logic [8*FRAME_MAX-1:0] frame_flat;

  // asynchronous assertion, synchronous release
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rs_q1 <= 1'b0;
      rs_q2 <= 1'b0;
    end else begin
      rs_q1 <= 1'b1;
      rs_q2 <= rs_q1;
    end
  end
  assign rst_core_n = rs_q2;

  stk_sp #(.PTR_W(PTR_W)) u_sp (
    .clk(clk), .rst_n(rst_core_n), .load_top(sp_load),
    .dec(sp_dec), .inc(sp_inc), .ptr(ptr)
  );

  stk_seq #(.PTR_W(PTR_W), .BASE(BASE), .IBIT(IBIT)) u_seq (
    .clk(clk), .rst_n(rst_core_n),
    .cmd_push(cmd_push), .cmd_pop(cmd_pop), .cmd_call(cmd_call),
    .cmd_ret(cmd_ret), .cmd_int(cmd_int), .cmd_iret(cmd_iret),
    .cmd_sp_rst(cmd_sp_rst), .push_data(push_data), .pc_in(pc_in),
    .a_in(a_in), .x_in(x_in), .cc_in(cc_in), .imask(imask), .ptr(ptr),
    .ram_rdata(ram_rdata), .sp_load(sp_load), .sp_dec(sp_dec),
    .sp_inc(sp_inc), .ram_addr(ram_addr), .ram_we(ram_we),
    .ram_re(ram_re), .ram_wdata(ram_wdata), .busy(busy),
    .int_acc(int_acc), .done_kind(done_kind), .frame_flat(frame_flat)
  );

  stk_imask u_imask (
    .clk(clk), .rst_n(rst_core_n), .int_acc(int_acc),
    .iret_done(iret_valid), .restored_i(cc_out[IBIT]),
    .irq_req(irq_req), .busy(busy), .imask(imask), .irq_grant(irq_grant)
  );

  assign sp         = {BASE_HI, ptr};
  assign pop_data   = frame_flat[7:0];
  assign pc_out     = frame_flat[15:0];
  assign x_out      = frame_flat[23:16];
  assign a_out      = frame_flat[31:24];
  assign cc_out     = frame_flat[39:32];
  assign pop_valid  = (done_kind == K_POP);
  assign ret_valid  = (done_kind == K_RET);
  assign iret_valid = (done_kind == K_IRET);

  AST_WR_AT_SP: assert property (@(posedge clk) disable iff (!rst_core_n)
    ram_we |-> (ram_addr == sp)); // R2
  AST_RD_ABOVE_SP: assert property (@(posedge clk) disable iff (!rst_core_n)
    ram_re |-> (ram_addr[PTR_W-1:0] == sp[PTR_W-1:0] + 1'b1)); // R3

endmodule

// File: tb/stk_ctx_unit_tb.sv
module stk_ctx_unit_tb;

  localparam int CLK_PERIOD = 10;
  localparam int OP_PUSH = 0, OP_POP = 1, OP_CALL = 2, OP_RET = 3,
                 OP_INT = 4, OP_IRET = 5, OP_RST = 6;

  logic clk = 1'b0;
  logic rst_n;
  logic cmd_push, cmd_pop, cmd_call, cmd_ret, cmd_int, cmd_iret, cmd_sp_rst;
  logic [7:0] push_data, a_in, x_in, cc_in, ram_rdata, ram_wdata;
  logic [15:0] pc_in, ram_addr, sp, pc_out;
  logic irq_req, ram_we, ram_re, busy, pop_valid, ret_valid, iret_valid;
  logic imask, irq_grant;
  logic [7:0] pop_data, a_out, x_out, cc_out;

  logic [7:0] mem   [64];
  logic [7:0] mem_m [64];
  logic [5:0] sp_m;
  logic       i_m, pend_m;
  int total = 0, bad = 0, wr_cnt = 0, addr_bad = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  stk_ctx_unit u_dut (
    .clk(clk), .rst_n(rst_n), .cmd_push(cmd_push), .cmd_pop(cmd_pop),
    .cmd_call(cmd_call), .cmd_ret(cmd_ret), .cmd_int(cmd_int),
    .cmd_iret(cmd_iret), .cmd_sp_rst(cmd_sp_rst), .push_data(push_data),
    .pc_in(pc_in), .a_in(a_in), .x_in(x_in), .cc_in(cc_in),
    .irq_req(irq_req), .ram_rdata(ram_rdata), .ram_addr(ram_addr),
    .ram_we(ram_we), .ram_re(ram_re), .ram_wdata(ram_wdata), .busy(busy),
    .sp(sp), .pop_data(pop_data), .pop_valid(pop_valid), .pc_out(pc_out),
    .ret_valid(ret_valid), .a_out(a_out), .x_out(x_out), .cc_out(cc_out),
    .iret_valid(iret_valid), .imask(imask), .irq_grant(irq_grant)
  );

  // synchronous-read stack RAM owned by the bench
  always @(posedge clk) begin
    if ((ram_we || ram_re) && ram_addr[15:6] != 10'd3) addr_bad++;
    if (ram_we) begin
      mem[ram_addr[5:0]] <= ram_wdata;
      wr_cnt++;
    end
    if (ram_re) ram_rdata <= mem[ram_addr[5:0]];
  end

  task automatic chk(input bit ok, input string what, input longint act, input longint exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s actual=%0h expected=%0h", what, act, exp);
    end
  endtask

  function automatic logic [7:0] cc_with_i(input logic [7:0] c, input logic i);
    logic [7:0] r;
    r = c;
    r[3] = i;
    return r;
  endfunction

  function automatic int busy_len(input int op);
    case (op)
      OP_PUSH: return 1;
      OP_POP, OP_CALL: return 2;
      OP_RET: return 3;
      OP_INT: return 5;
      OP_IRET: return 6;
      default: return 0;
    endcase
  endfunction

  task automatic check_ram(input string what);
    int mis = 0;
    for (int k = 0; k < 64; k++) if (mem[k] !== mem_m[k]) mis++;
    chk(mis == 0, what, mis, 0);
  endtask

  task automatic do_op(input int op, input logic [6:0] extra, input logic irq,
                       input logic inject, input logic [7:0] d, input logic [15:0] pc,
                       input logic [7:0] a, input logic [7:0] x, input logic [7:0] cc);
    int n, w0, ew;
    logic [7:0] e0, e1, e2, e3, e4;
    logic [6:0] mask;
    ew = 0; e0 = 0; e1 = 0; e2 = 0; e3 = 0; e4 = 0;
    case (op)
      OP_PUSH: begin ew = 1; mem_m[sp_m] = d; sp_m--; end
      OP_POP:  begin sp_m++; e0 = mem_m[sp_m]; end
      OP_CALL: begin
        ew = 2;
        mem_m[sp_m] = pc[7:0];  sp_m--;
        mem_m[sp_m] = pc[15:8]; sp_m--;
      end
      OP_RET: begin sp_m++; e1 = mem_m[sp_m]; sp_m++; e0 = mem_m[sp_m]; end
      OP_INT: begin
        ew = 5;
        mem_m[sp_m] = pc[7:0];  sp_m--;
        mem_m[sp_m] = pc[15:8]; sp_m--;
        mem_m[sp_m] = x;        sp_m--;
        mem_m[sp_m] = a;        sp_m--;
        mem_m[sp_m] = cc_with_i(cc, i_m); sp_m--;
        i_m = 1'b1;
      end
      OP_IRET: begin
        sp_m++; e4 = mem_m[sp_m];
        sp_m++; e3 = mem_m[sp_m];
        sp_m++; e2 = mem_m[sp_m];
        sp_m++; e1 = mem_m[sp_m];
        sp_m++; e0 = mem_m[sp_m];
      end
      default: sp_m = 6'h3F;
    endcase
    if (irq) pend_m = 1'b1;
    else if (op == OP_INT) pend_m = 1'b0;

    mask = 7'(1 << op) | extra;
    @(negedge clk);
    push_data = d; pc_in = pc; a_in = a; x_in = x; cc_in = cc; irq_req = irq;
    {cmd_sp_rst, cmd_iret, cmd_int, cmd_ret, cmd_call, cmd_pop, cmd_push} = mask;
    w0 = wr_cnt;
    @(negedge clk);
    {cmd_sp_rst, cmd_iret, cmd_int, cmd_ret, cmd_call, cmd_pop, cmd_push} = 7'd0;
    irq_req = 1'b0;
    n = 0;
    while (busy && n < 20) begin
      cmd_push = inject && (n == 0);
      n++;
      @(negedge clk);
    end
    cmd_push = 1'b0;

    chk(n == busy_len(op), "R8 busy length", n, busy_len(op));
    chk(wr_cnt - w0 == ew, "R8 write count", wr_cnt - w0, ew);
    case (op)
      OP_POP:  chk(pop_valid === 1'b1 && pop_data === e0, "R2 pop data", {pop_valid, pop_data}, {1'b1, e0});
      OP_RET:  chk(ret_valid === 1'b1 && pc_out === {e1, e0}, "R4 return pc", {ret_valid, pc_out}, {1'b1, e1, e0});
      OP_IRET: begin
        chk(iret_valid === 1'b1 && pc_out === {e1, e0}, "R7 restored pc", {iret_valid, pc_out}, {1'b1, e1, e0});
        chk(x_out === e2 && a_out === e3 && cc_out === e4, "R7 restored x a cc",
            {x_out, a_out, cc_out}, {e2, e3, e4});
        i_m = e4[3];
      end
      default: ;
    endcase
    @(negedge clk);
    chk(sp === {10'd3, sp_m}, "R3 stack pointer", sp, {10'd3, sp_m});
    chk(imask === i_m, (op == OP_INT) ? "R6 mask after entry" : "R7 mask", imask, i_m);
    chk(irq_grant === (pend_m & ~i_m), "R10 grant", irq_grant, pend_m & ~i_m);
    check_ram(op == OP_INT ? "R5 frame contents" : "R2 ram contents");
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    bad++; total++;
    $display("FAIL watchdog expired actual=0 expected=1");
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    void'($urandom(32'd4711));
    rst_n = 1'b0; irq_req = 1'b0;
    {cmd_sp_rst, cmd_iret, cmd_int, cmd_ret, cmd_call, cmd_pop, cmd_push} = 7'd0;
    push_data = 0; pc_in = 0; a_in = 0; x_in = 0; cc_in = 0;
    for (int k = 0; k < 64; k++) begin
      mem[k] = 8'($urandom);
      mem_m[k] = mem[k];
    end
    sp_m = 6'h3F; i_m = 1'b0; pend_m = 1'b0;
    repeat (4) @(negedge clk);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);

    chk(sp === 16'h00FF && busy === 1'b0, "R1 reset sp busy", {sp, busy}, {16'h00FF, 1'b0});
    chk(imask === 1'b0 && irq_grant === 1'b0, "R1 reset mask grant", {imask, irq_grant}, 2'b00);
    chk(ram_we === 1'b0 && ram_re === 1'b0, "R1 reset ram idle", {ram_we, ram_re}, 2'b00);

    // R3: pop from the top wraps up to 00C0h, push from 00C0h wraps down
    do_op(OP_POP, 7'd0, 0, 0, 8'h00, 16'h0, 8'h0, 8'h0, 8'h0);
    chk(sp === 16'h00C0, "R3 wrap up", sp, 16'h00C0);
    do_op(OP_PUSH, 7'd0, 0, 0, 8'h5A, 16'h0, 8'h0, 8'h0, 8'h0);
    chk(sp === 16'h00FF && mem[0] === 8'h5A, "R3 wrap down", {sp, mem[0]}, {16'h00FF, 8'h5A});
    // R2 push then pop
    do_op(OP_PUSH, 7'd0, 0, 0, 8'hC3, 16'h0, 8'h0, 8'h0, 8'h0);
    do_op(OP_PUSH, 7'd0, 0, 0, 8'h3C, 16'h0, 8'h0, 8'h0, 8'h0);
    do_op(OP_POP, 7'd0, 0, 0, 8'h00, 16'h0, 8'h0, 8'h0, 8'h0);
    // R9 stack pointer reset
    do_op(OP_RST, 7'd0, 0, 0, 8'h00, 16'h0, 8'h0, 8'h0, 8'h0);
    chk(sp === 16'h00FF, "R9 sp reload", sp, 16'h00FF);
    // R4 call and return, with a push injected while busy (R8 ignore)
    do_op(OP_CALL, 7'd0, 0, 1, 8'h77, 16'h1234, 8'h0, 8'h0, 8'h0);
    do_op(OP_RET, 7'd0, 0, 0, 8'h00, 16'h0, 8'h0, 8'h0, 8'h0);
    chk(pc_out === 16'h1234, "R4 pc round trip", pc_out, 16'h1234);
    // R5 R6 R10: entry with coincident request; CC stored with old mask 0
    do_op(OP_INT, 7'd0, 1, 0, 8'h00, 16'hBEEF, 8'hA1, 8'h5E, 8'hFF);
    chk(mem[6'h3B] === 8'hF7, "R5 stored cc mask bit", mem[6'h3B], 8'hF7);
    chk(irq_grant === 1'b0, "R10 grant held by mask", irq_grant, 1'b0);
    // R7: return restores mask 0, latched request is granted
    do_op(OP_IRET, 7'd0, 0, 0, 8'h00, 16'h0, 8'h0, 8'h0, 8'h0);
    chk(irq_grant === 1'b1 && imask === 1'b0, "R10 grant after return", {irq_grant, imask}, 2'b10);
    do_op(OP_INT, 7'd0, 0, 0, 8'h00, 16'h4321, 8'h11, 8'h22, 8'h00);
    do_op(OP_IRET, 7'd0, 0, 0, 8'h00, 16'h0, 8'h0, 8'h0, 8'h0);
    // R11 priority
    do_op(OP_PUSH, 7'b0000010, 0, 0, 8'h99, 16'h0, 8'h0, 8'h0, 8'h0);
    do_op(OP_RST, 7'b0000001, 0, 0, 8'h66, 16'h0, 8'h0, 8'h0, 8'h0);
    do_op(OP_INT, 7'b0000100, 0, 0, 8'h00, 16'hCAFE, 8'h01, 8'h02, 8'h08);
    do_op(OP_IRET, 7'b0001000, 0, 0, 8'h00, 16'h0, 8'h0, 8'h0, 8'h0);

    // constrained random mix
    for (int it = 0; it < 400; it++) begin
      int r, op;
      r = $urandom_range(0, 99);
      if      (r < 30) op = OP_PUSH;
      else if (r < 55) op = OP_POP;
      else if (r < 67) op = OP_CALL;
      else if (r < 79) op = OP_RET;
      else if (r < 87) op = OP_INT;
      else if (r < 95) op = OP_IRET;
      else             op = OP_RST;
      do_op(op, 7'd0, ($urandom_range(0, 7) == 0),
            (op != OP_RST) && ($urandom_range(0, 4) == 0),
            8'($urandom), 16'($urandom), 8'($urandom), 8'($urandom), 8'($urandom));
    end
    chk(addr_bad == 0, "R3 addresses inside window", addr_bad, 0);

    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

endmodule